// File: doc/BRIEF.md
# Eight-bit Timer with Power-of-Two Clock Divider

This block is an 8-bit up-counter advanced by a clock-enable from a prescaler. A 4-bit select picks one of fifteen power-of-two division ratios, from every clock down to one advance per 16384 clocks, or it stops the counter. The wrap point of the counter is normally 0xFF. A separate limit register can instead set the wrap point, without affecting the threshold of the output channel.

Output channel A compares the count against its own threshold and drives a pin. A 2-bit action code selects toggle, clear, set or no drive. In pulse-width mode the pin is also driven at each restart from zero, so the threshold sets the duty cycle and the limit register sets the period. A second threshold (B) only raises a flag. An overflow flag marks each wrap of the counter.

Top module: `pow2_timer`

## Requirements
- R1: With the clock select `div_sel` at 0 the counter does not advance and holds its value.
- R2: With `div_sel` = n (1 to 15) the counter advances once every 2^(n-1) clock cycles. Measured from reset release, the first rising edge is E0 and advances happen at edges E(N), E(2N), and so on.
- R3: A change of `div_sel` restarts the divider. No advance occurs at the edge that first samples the new value (E0), and the next advance occurs exactly 2^(n-1) edges after it.
- R4: With `clr_on_limit` and `pwm_mode` both 0 the top is 0xFF, and the count wraps from 0xFF to 0.
- R5: With `clr_on_limit` or `pwm_mode` set, the top is `limit`, and the count runs 0..`limit` and then returns to 0.
- R6: `ovf` is high for the single clock cycle after an advance edge at which the count equalled the top. At that point the count reads 0.
- R7: `hit_a` (`hit_b`) is high for the single clock cycle after an advance edge at which the count equalled `thr_a` (`thr_b`).
- R8: `wave_oe` is 1 exactly when `wave_act` is not 00. With action 00 the pin `wave` keeps its value.
- R9: Outside pulse-width mode, on a compare-A advance, `wave_act` 01 toggles `wave`, 10 clears it and 11 sets it. The pin changes at the same edge as the count.
- R10: In pulse-width mode, action 10 sets `wave` when the count restarts at 0 and clears it on the compare-A match. Action 11 does the opposite. When `thr_a` equals the top, the compare action wins.
- R11: After reset, `count`, `wave`, `hit_a`, `hit_b` and `ovf` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr_on_limit | input | 1 | Wrap at `limit` instead of 0xFF |
| pwm_mode | input | 1 | Pulse-width mode for channel A, wrap at `limit` |
| wave_act | input | 2 | Channel A action: 00 none, 01 toggle, 10 clear, 11 set |
| div_sel | input | 4 | 0 stops; n divides by 2^(n-1) |
| thr_a | input | 8 | Channel A threshold |
| thr_b | input | 8 | Channel B threshold (flag only) |
| limit | input | 8 | Wrap point in limit and pulse-width modes |
| count | output | 8 | Counter value |
| wave | output | 1 | Channel A pin value |
| wave_oe | output | 1 | Channel A pin drive enable |
| hit_a | output | 1 | Compare-A pulse |
| hit_b | output | 1 | Compare-B pulse |
| ovf | output | 1 | Wrap pulse |

## Verification
The divider state shows only through the spacing of count advances. A wrong restart or a wrong mask appears at the first advance after a select change, at most 16384 cycles later, as an advance at the wrong edge. A wrong top or a wrong wrap shows at the next pass through the limit, as a count above `limit` or a missing `ovf` pulse. A wrong pin state stays on `wave` and shows at the next sample, because a set or clear action rewrites the pin only at the next match.

// File: rtl/pow2_timer.sv
module pow2_timer #(
  parameter int CW = 8,
  parameter int SW = 4,
  parameter int PW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_on_limit,
  input  logic          pwm_mode,
  input  logic [1:0]    wave_act,
  input  logic [SW-1:0] div_sel,
  input  logic [CW-1:0] thr_a,
  input  logic [CW-1:0] thr_b,
  input  logic [CW-1:0] limit,
  output logic [CW-1:0] count,
  output logic          wave,
  output logic          wave_oe,
  output logic          hit_a,
  output logic          hit_b,
  output logic          ovf
);

  logic [SW-1:0] sel_q;
  logic [PW-1:0] div_cnt;
  logic [PW-1:0] div_mask;
  logic          tick;
  logic [CW-1:0] top;
  logic          at_top;
  logic          match_a;
  logic          wave_nx;

  assign div_mask = (sel_q == '0) ? '0 : ((PW'(1) << (sel_q - SW'(1))) - PW'(1));
  assign tick     = (sel_q != '0) && (div_sel == sel_q) && ((div_cnt & div_mask) == div_mask);
  assign top      = (clr_on_limit || pwm_mode) ? limit : '1;
  assign at_top   = (count == top);
  assign match_a  = (count == thr_a);
  assign wave_oe  = (wave_act != 2'b00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      div_cnt <= '0;
    end else begin
      sel_q <= div_sel;
      if (div_sel != sel_q)
        div_cnt <= '0;
      else if (sel_q != '0)
        div_cnt <= div_cnt + PW'(1);
    end
  end

  always_comb begin
    wave_nx = wave;
    if (tick) begin
      if (pwm_mode && at_top) begin
        if (wave_act == 2'b10) wave_nx = 1'b1;
        if (wave_act == 2'b11) wave_nx = 1'b0;
      end
      if (match_a) begin
        case (wave_act)
          2'b01:   wave_nx = ~wave;
          2'b10:   wave_nx = 1'b0;
          2'b11:   wave_nx = 1'b1;
          default: wave_nx = wave;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      wave  <= 1'b0;
      hit_a <= 1'b0;
      hit_b <= 1'b0;
      ovf   <= 1'b0;
    end else begin
      hit_a <= tick && match_a;
      hit_b <= tick && (count == thr_b);
      ovf   <= tick && at_top;
      wave  <= wave_nx;
      if (tick)
        count <= at_top ? '0 : count + CW'(1);
    end
  end

  // R1
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q == '0) |=> $stable(count));

  // R3
  sel_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (div_sel != sel_q) |=> $stable(count));

  // R5
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count != $past(count)) |-> ((count == CW'($past(count) + CW'(1))) || (count == '0)));

  // R6
  ovf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> (count == '0));

  // R9
  clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wave_act == 2'b10 && !pwm_mode) |=> !$rose(wave));

  // R9
  set_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wave_act == 2'b11 && !pwm_mode) |=> !$fell(wave));

endmodule

// File: tb/pow2_timer_bench.sv
module pow2_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 11;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr_on_limit = 1'b0;
  logic       pwm_mode = 1'b0;
  logic [1:0] wave_act = 2'b00;
  logic [3:0] div_sel = 4'd0;
  logic [7:0] thr_a = 8'd0;
  logic [7:0] thr_b = 8'd0;
  logic [7:0] limit = 8'd0;
  logic [7:0] count;
  logic       wave, wave_oe, hit_a, hit_b, ovf;

  int n_vec = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pow2_timer u_pow2_timer (
    .clk(clk), .rst_n(rst_n), .clr_on_limit(clr_on_limit), .pwm_mode(pwm_mode),
    .wave_act(wave_act), .div_sel(div_sel), .thr_a(thr_a), .thr_b(thr_b),
    .limit(limit), .count(count), .wave(wave), .wave_oe(wave_oe),
    .hit_a(hit_a), .hit_b(hit_b), .ovf(ovf)
  );

  // sel, clr, pwm, act, a, b, limit, edges, exp count, exp wave
  localparam logic [56:0] VECS [0:NV-1] = '{
    {4'd1,  1'b0, 1'b0, 2'b00, 8'd0, 8'd0, 8'd0, 16'd11,    8'd10, 1'b0}, // R2
    {4'd4,  1'b0, 1'b0, 2'b00, 8'd0, 8'd0, 8'd0, 16'd41,    8'd5,  1'b0}, // R2
    {4'd1,  1'b1, 1'b0, 2'b00, 8'd0, 8'd0, 8'd9, 16'd26,    8'd5,  1'b0}, // R5
    {4'd1,  1'b0, 1'b0, 2'b01, 8'd3, 8'd0, 8'd0, 16'd21,    8'd20, 1'b1}, // R9 toggle
    {4'd1,  1'b0, 1'b0, 2'b11, 8'd7, 8'd0, 8'd0, 16'd9,     8'd8,  1'b1}, // R9 set
    {4'd1,  1'b0, 1'b1, 2'b10, 8'd4, 8'd0, 8'd9, 16'd14,    8'd3,  1'b1}, // R10 set at restart
    {4'd1,  1'b0, 1'b1, 2'b10, 8'd4, 8'd0, 8'd9, 16'd16,    8'd5,  1'b0}, // R10 clear at match
    {4'd1,  1'b0, 1'b1, 2'b11, 8'd4, 8'd0, 8'd9, 16'd16,    8'd5,  1'b1}, // R10 inverted
    {4'd15, 1'b0, 1'b0, 2'b00, 8'd0, 8'd0, 8'd0, 16'd16385, 8'd1,  1'b0}, // R2 widest
    {4'd0,  1'b0, 1'b0, 2'b00, 8'd0, 8'd0, 8'd0, 16'd50,    8'd0,  1'b0}, // R1
    {4'd2,  1'b0, 1'b0, 2'b00, 8'd0, 8'd0, 8'd0, 16'd20,    8'd9,  1'b0}  // R2
  };

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic restart(input logic [3:0] s, input logic c, input logic p,
                         input logic [1:0] ac, input logic [7:0] a,
                         input logic [7:0] b, input logic [7:0] l);
    @(negedge clk);
    rst_n = 1'b0;
    div_sel = s; clr_on_limit = c; pwm_mode = p; wave_act = ac;
    thr_a = a; thr_b = b; limit = l;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run(input int k);
    repeat (k) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 200000) begin
      @(posedge clk);
      cyc++;
    end
    n_bad++;
    $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 200000);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] c0;
    // R11 reset state
    @(negedge clk);
    chk("R11 count", count, 0);
    chk("R11 wave", wave, 0);
    chk("R11 flags", {hit_a, hit_b, ovf}, 0);

    for (int i = 0; i < NV; i++) begin
      restart(VECS[i][56:53], VECS[i][52], VECS[i][51], VECS[i][50:49],
              VECS[i][48:41], VECS[i][40:33], VECS[i][32:25]);
      run(int'(VECS[i][24:9]));
      chk("R1/R2/R5 vector count", count, int'(VECS[i][8:1]));
      chk("R9/R10 vector wave", wave, int'(VECS[i][0]));
    end

    // R8 output enable and hold with action 00
    restart(4'd1, 1'b0, 1'b0, 2'b00, 8'd3, 8'd0, 8'd0);
    chk("R8 oe for 00", wave_oe, 0);
    wave_act = 2'b01;
    #1 chk("R8 oe for 01", wave_oe, 1);
    run(8);
    chk("R8 wave after toggle", wave, 1);
    wave_act = 2'b10;
    run(1);
    wave_act = 2'b00;
    run(300);
    chk("R8 wave held under 00", wave, 1);

    // R4 / R6 wrap at 0xFF
    restart(4'd1, 1'b0, 1'b0, 2'b00, 8'd0, 8'd0, 8'd0);
    run(256);
    chk("R4 count at 0xFF", count, 255);
    chk("R6 no ovf before wrap", ovf, 0);
    run(1);
    chk("R4 wrap to zero", count, 0);
    chk("R6 ovf pulse", ovf, 1);
    run(1);
    chk("R6 ovf one cycle", ovf, 0);

    // R7 compare pulses
    restart(4'd1, 1'b0, 1'b0, 2'b00, 8'd5, 8'd7, 8'd0);
    run(7);
    chk("R7 count", count, 6);
    chk("R7 hit_a pulse", hit_a, 1);
    run(1);
    chk("R7 hit_a one cycle", hit_a, 0);
    run(1);
    chk("R7 hit_b pulse", hit_b, 1);
    chk("R7 hit_a quiet", hit_a, 0);

    // R3 select change restarts divider
    restart(4'd3, 1'b0, 1'b0, 2'b00, 8'd0, 8'd0, 8'd0);
    run(22);
    c0 = count;
    div_sel = 4'd2;
    run(2);
    chk("R3 no advance at change", count, c0);
    run(1);
    chk("R3 advance after restart", count, c0 + 8'd1);

    // R1 stop mid-run
    div_sel = 4'd0;
    run(1);
    c0 = count;
    run(40);
    chk("R1 held when stopped", count, c0);

    // R10 compare wins at top
    restart(4'd1, 1'b0, 1'b1, 2'b10, 8'd9, 8'd0, 8'd9);
    run(35);
    chk("R10 compare wins over restart", wave, 0);
    chk("R5 count bounded by limit", count, 4);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule